// File: doc/BRIEF.md
# Authenticated Performance Counter Gating

This block is a compact performance-monitor unit. It holds a bank of event counters and one free-running cycle counter. It decides, from the core's debug-authentication status, whether each of them may advance. Event counting is allowed only outside halted debug state, and only while non-invasive debug is both permitted and enabled. The cycle counter ignores that permission. It stops in halted debug state, and it also stops when a hold control bit is set while event counting is prohibited.

Events that may be counted can also be mirrored onto an export bus for an external trace or profiling consumer, when an export control bit is set. A single gate decision feeds both the counter increments and the export path, so no prohibited event reaches either one. Software reaches the counters and the sticky overflow flags through a simple word-wide register port. Single-cycle clear pulses zero the event bank or the cycle counter.

Top module: `perf_gate_unit`

## Requirements
- R1: While `dbg_halted` is 1, no counter increments and `evt_export` stays 0, whatever the other inputs are.
- R2: Outside halted state with `ni_dbg_allow` = 1, each enabled event counter adds one for every cycle its `evt_pulse` bit is 1, and the cycle counter adds one every cycle whatever `ctl_cyc_hold` is.
- R3: Outside halted state with `ni_dbg_allow` = 0, event pulses never change an event counter, and the cycle counter keeps counting while `ctl_cyc_hold` = 0.
- R4: Outside halted state with `ni_dbg_allow` = 0 and `ctl_cyc_hold` = 1, the cycle counter holds its value.
- R5: `evt_export[i]` is 1 in the cycle after a clock edge at which `evt_pulse[i]` = 1, `ctl_export_en` = 1 and event counting was permitted. In every other case it is 0. It does not depend on the enable bits.
- R6: A prohibition, whether from halted state or from losing permission, takes effect at the same clock edge. A grant takes effect one edge later: a pulse in the first cycle after permission returns is not counted.
- R7: An event counter increments only when `ctl_glob_en` and its `evt_en` bit are both 1. The cycle counter increments only when `ctl_glob_en` and `cyc_en` are both 1.
- R8: An increment that takes a counter from all ones to zero sets its sticky overflow bit. Event counter i uses bit i and the cycle counter uses bit N_EVT. Writing 1 to a bit at the overflow address clears it. A wrap in the same cycle wins over the clear.
- R9: Register map: addresses 0..N_EVT-1 are the event counters, N_EVT is the cycle counter, and N_EVT+1 holds the overflow flags in its low bits. Other addresses read 0. `reg_rdata` follows `reg_addr` combinationally. A write wins over a clear pulse, and a clear pulse wins over an increment.
- R10: `evt_clr` zeroes every event counter and `cyc_clr` zeroes the cycle counter. Each acts once per cycle in which it is high.
- R11: After reset, all counters, overflow flags and export bits are 0, and no counting happens in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbg_halted | input | 1 | Core is in (or entering) halted debug state |
| ni_dbg_allow | input | 1 | Non-invasive debug permitted and enabled |
| ctl_cyc_hold | input | 1 | Stop cycle counter while event counting is prohibited |
| ctl_export_en | input | 1 | Allow events onto the export bus |
| ctl_glob_en | input | 1 | Global counter enable |
| cyc_en | input | 1 | Cycle counter enable |
| evt_en | input | N_EVT | Per-event-counter enables |
| evt_pulse | input | N_EVT | Per-counter event pulses |
| evt_clr | input | 1 | Zero all event counters (pulse) |
| cyc_clr | input | 1 | Zero the cycle counter (pulse) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | clog2(N_EVT+2) | Register address |
| reg_wdata | input | CNT_W | Register write data |
| reg_rdata | output | CNT_W | Register read data |
| evt_count | output | N_EVT*CNT_W | Event counter values, counter i at bits i*CNT_W upward |
| cyc_count | output | CNT_W | Cycle counter value |
| ovf_flags | output | N_EVT+1 | Sticky overflow flags |
| evt_export | output | N_EVT | Registered exported events |

## Verification
A stale or wrong registered gate shows up as a counter that moves, or stays still, one edge after `dbg_halted` or `ni_dbg_allow` changes. Because the reference model is compared on every clock, such a miscount is seen on `evt_count` or `cyc_count` at the very next falling edge, and it persists from then on. A wrong export qualification shows on `evt_export` in the cycle right after the offending pulse. A lost or spurious overflow bit stays visible on `ovf_flags` from the cycle after the wrap until software clears it. Directed sequences force the wrap, the write-over-clear priority and the one-edge grant lag, so each of these paths is driven at least once.

// File: rtl/pgu_pkg.sv
package pgu_pkg;

   // Authentication-derived permission pair
   typedef struct packed {
      logic evt;
      logic cyc;
   } pgu_gate_t;

   // Register port slot classes
   typedef enum logic [1:0] {
      SLOT_EVT  = 2'd0,
      SLOT_CYC  = 2'd1,
      SLOT_OVF  = 2'd2,
      SLOT_NONE = 2'd3
   } pgu_slot_e;

   function automatic pgu_gate_t pgu_permit(input logic halted,
                                            input logic allow,
                                            input logic hold);
      pgu_gate_t g;
      g.evt = !halted && allow;
      g.cyc = !halted && (allow || !hold);
      return g;
   endfunction

endpackage

// File: rtl/pgu_auth_gate.sv
module pgu_auth_gate #(
   parameter bit EARLY_STOP = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic halted,
   input  logic allow,
   input  logic hold,
   output logic evt_gate,
   output logic cyc_gate
);
   import pgu_pkg::*;

   pgu_gate_t now_g;
   pgu_gate_t reg_g;

   assign now_g = pgu_permit(halted, allow, hold);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_g <= '0;
      end else begin
         reg_g <= now_g;
      end
   end

   generate
      if (EARLY_STOP) begin : g_early
         // Registered grant, immediate revoke
         assign evt_gate = reg_g.evt && now_g.evt;
         assign cyc_gate = reg_g.cyc && now_g.cyc;

         AST_GRANT_LAG: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(evt_gate) |-> $past(allow && !halted)); // R6
         AST_REVOKE_NOW: assert property (@(posedge clk) disable iff (!rst_n)
            (halted || !allow) |-> !evt_gate); // R6
      end else begin : g_late
         assign evt_gate = reg_g.evt;
         assign cyc_gate = reg_g.cyc;
      end
   endgenerate

endmodule

// File: rtl/pgu_counter.sv
module pgu_counter #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] value,
   output logic         wrap
);
   localparam logic [W-1:0] ONE = W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value <= '0;
      end else if (wr) begin
         value <= wdata;
      end else if (clr) begin
         value <= '0;
      end else if (inc) begin
         value <= value + ONE;
      end
   end

   assign wrap = inc && !wr && !clr && (&value);

   AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> value == $past(wdata)); // R9
   AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !wr) |=> value == '0); // R10

endmodule

// File: rtl/pgu_ovf_bank.sv
module pgu_ovf_bank #(
   parameter int NB = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NB-1:0] set,
   input  logic          clr_wr,
   input  logic [NB-1:0] clr_mask,
   output logic [NB-1:0] flags
);
   logic [NB-1:0] keep;

   assign keep = clr_wr ? ~clr_mask : '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags <= '0;
      end else begin
         flags <= (flags & keep) | set;
      end
   end

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_wr |=> (flags & $past(flags)) == $past(flags)); // R8
   AST_OVF_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      |set |=> (flags & $past(set)) == $past(set)); // R8

endmodule

// File: rtl/pgu_export.sv
module pgu_export #(
   parameter int N     = 4,
   parameter bit STAGE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] pulse,
   input  logic         x_en,
   input  logic         gate,
   output logic [N-1:0] exp_o
);
   logic [N-1:0] qual;

   assign qual = (x_en && gate) ? pulse : '0;

   generate
      if (STAGE) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               exp_o <= '0;
            end else begin
               exp_o <= qual;
            end
         end

         AST_EXPORT_NEEDS_X: assert property (@(posedge clk) disable iff (!rst_n)
            (|exp_o) |-> $past(x_en)); // R5
         AST_EXPORT_NEEDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
            ((exp_o & ~$past(pulse)) == '0)); // R5
      end else begin : g_comb
         assign exp_o = qual;
      end
   endgenerate

endmodule

// File: rtl/perf_gate_unit.sv
module perf_gate_unit #(
   parameter int N_EVT        = 4,
   parameter int CNT_W        = 32,
   parameter bit EARLY_STOP   = 1'b1,
   parameter bit EXPORT_STAGE = 1'b1,
   localparam int AW          = $clog2(N_EVT + 2),
   localparam int NB          = N_EVT + 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   dbg_halted,
   input  logic                   ni_dbg_allow,
   input  logic                   ctl_cyc_hold,
   input  logic                   ctl_export_en,
   input  logic                   ctl_glob_en,
   input  logic                   cyc_en,
   input  logic [N_EVT-1:0]       evt_en,
   input  logic [N_EVT-1:0]       evt_pulse,
   input  logic                   evt_clr,
   input  logic                   cyc_clr,
   input  logic                   reg_wr,
   input  logic [AW-1:0]          reg_addr,
   input  logic [CNT_W-1:0]       reg_wdata,
   output logic [CNT_W-1:0]       reg_rdata,
   output logic [N_EVT*CNT_W-1:0] evt_count,
   output logic [CNT_W-1:0]       cyc_count,
   output logic [NB-1:0]          ovf_flags,
   output logic [N_EVT-1:0]       evt_export
);
   import pgu_pkg::*;

   localparam logic [AW-1:0] CYC_ADDR = AW'(N_EVT);
   localparam logic [AW-1:0] OVF_ADDR = AW'(N_EVT + 1);

   generate
      if (N_EVT < 1 || N_EVT > 30) begin : g_bad_n
         $error("perf_gate_unit: N_EVT out of range");
      end
      if (CNT_W < NB || CNT_W > 64) begin : g_bad_w
         $error("perf_gate_unit: CNT_W must hold the overflow word and be at most 64");
      end
   endgenerate

   logic          evt_gate;
   logic          cyc_gate;
   logic [NB-1:0] wrap_v;
   pgu_slot_e     slot;

   pgu_auth_gate #(.EARLY_STOP(EARLY_STOP)) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .halted   (dbg_halted),
      .allow    (ni_dbg_allow),
      .hold     (ctl_cyc_hold),
      .evt_gate (evt_gate),
      .cyc_gate (cyc_gate)
   );

   generate
      for (genvar i = 0; i < N_EVT; i++) begin : g_evt
         logic wr_i;
         logic inc_i;
         assign wr_i  = reg_wr && (reg_addr == AW'(i));
         assign inc_i = evt_pulse[i] && ctl_glob_en && evt_en[i] && evt_gate;

         pgu_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (wr_i),
            .wdata (reg_wdata),
            .clr   (evt_clr),
            .inc   (inc_i),
            .value (evt_count[i*CNT_W +: CNT_W]),
            .wrap  (wrap_v[i])
         );
      end
   endgenerate

   logic cyc_wr;
   logic cyc_inc;
   assign cyc_wr  = reg_wr && (reg_addr == CYC_ADDR);
   assign cyc_inc = ctl_glob_en && cyc_en && cyc_gate;

   pgu_counter #(.W(CNT_W)) u_cyc (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (cyc_wr),
      .wdata (reg_wdata),
      .clr   (cyc_clr),
      .inc   (cyc_inc),
      .value (cyc_count),
      .wrap  (wrap_v[N_EVT])
   );

   pgu_ovf_bank #(.NB(NB)) u_ovf (
      .clk      (clk),
      .rst_n    (rst_n),
      .set      (wrap_v),
      .clr_wr   (reg_wr && (reg_addr == OVF_ADDR)),
      .clr_mask (reg_wdata[NB-1:0]),
      .flags    (ovf_flags)
   );

   pgu_export #(.N(N_EVT), .STAGE(EXPORT_STAGE)) u_exp (
      .clk   (clk),
      .rst_n (rst_n),
      .pulse (evt_pulse),
      .x_en  (ctl_export_en),
      .gate  (evt_gate),
      .exp_o (evt_export)
   );

   // Read decode
   always_comb begin
      if (reg_addr < CYC_ADDR)       slot = SLOT_EVT;
      else if (reg_addr == CYC_ADDR) slot = SLOT_CYC;
      else if (reg_addr == OVF_ADDR) slot = SLOT_OVF;
      else                           slot = SLOT_NONE;
   end

   always_comb begin
      reg_rdata = '0;
      unique case (slot)
         SLOT_EVT: begin
            for (int k = 0; k < N_EVT; k++) begin
               if (reg_addr == AW'(k)) reg_rdata = evt_count[k*CNT_W +: CNT_W];
            end
         end
         SLOT_CYC: reg_rdata = cyc_count;
         SLOT_OVF: reg_rdata[NB-1:0] = ovf_flags;
         default:  reg_rdata = '0;
      endcase
   end

   AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_halted && !reg_wr && !evt_clr && !cyc_clr) |=>
         ($stable(evt_count) && $stable(cyc_count))); // R1
   AST_HALT_NO_EXPORT: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_halted |=> evt_export == '0); // R1
   AST_EVT_PROHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
      (!ni_dbg_allow && !reg_wr && !evt_clr) |=> $stable(evt_count)); // R3
   AST_CYC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ni_dbg_allow && ctl_cyc_hold && !reg_wr && !cyc_clr) |=> $stable(cyc_count)); // R4
   AST_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_glob_en && !reg_wr && !evt_clr && !cyc_clr) |=>
         ($stable(evt_count) && $stable(cyc_count))); // R7

endmodule

// File: tb/sim_perf_gate_unit.sv
`timescale 1ns/1ps
module sim_perf_gate_unit;
   localparam int N  = 4;
   localparam int W  = 32;
   localparam int AW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic halted = 0, allow = 0, hold = 0, xen = 0, gen = 0, cen = 0;
   logic [N-1:0] een = '0, pulse = '0;
   logic eclr = 0, cclr = 0, wr = 0;
   logic [AW-1:0] addr = '0;
   logic [W-1:0] wdata = '0;
   logic [W-1:0] rdata;
   logic [N*W-1:0] ecount;
   logic [W-1:0] ccount;
   logic [N:0] ovf;
   logic [N-1:0] expo;

   int checks = 0;
   int errors = 0;
   bit run_chk = 0;
   string tag = "R11";
   logic [15:0] lfsr = 16'hACE1;

   always #2 clk = ~clk;

   perf_gate_unit u0 (
      .clk(clk), .rst_n(rst_n), .dbg_halted(halted), .ni_dbg_allow(allow),
      .ctl_cyc_hold(hold), .ctl_export_en(xen), .ctl_glob_en(gen), .cyc_en(cen),
      .evt_en(een), .evt_pulse(pulse), .evt_clr(eclr), .cyc_clr(cclr),
      .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata),
      .evt_count(ecount), .cyc_count(ccount), .ovf_flags(ovf), .evt_export(expo)
   );

   // Behavioural reference model
   logic [W-1:0] m_evt [N];
   logic [W-1:0] m_cyc;
   logic [N:0]   m_ovf;
   logic [N-1:0] m_exp;
   bit m_eok, m_cok;

   always @(posedge clk) begin : model
      bit en_now, cn_now, eg, cg;
      logic [N:0] wv;
      if (!rst_n) begin
         for (int i = 0; i < N; i++) m_evt[i] = '0;
         m_cyc = '0; m_ovf = '0; m_exp = '0; m_eok = 0; m_cok = 0;
      end else begin
         en_now = !halted && allow;
         cn_now = !halted && (allow || !hold);
         eg = m_eok && en_now;
         cg = m_cok && cn_now;
         wv = '0;
         for (int i = 0; i < N; i++) begin
            if (wr && addr == AW'(i)) m_evt[i] = wdata;
            else if (eclr) m_evt[i] = '0;
            else if (pulse[i] && gen && een[i] && eg) begin
               if (m_evt[i] == '1) wv[i] = 1'b1;
               m_evt[i] = m_evt[i] + 1;
            end
         end
         if (wr && addr == AW'(N)) m_cyc = wdata;
         else if (cclr) m_cyc = '0;
         else if (gen && cen && cg) begin
            if (m_cyc == '1) wv[N] = 1'b1;
            m_cyc = m_cyc + 1;
         end
         if (wr && addr == AW'(N+1)) m_ovf = m_ovf & ~wdata[N:0];
         m_ovf = m_ovf | wv;
         m_exp = (xen && eg) ? pulse : '0;
         m_eok = en_now;
         m_cok = cn_now;
      end
   end

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp_v, input string what);
      checks++;
      if (act !== exp_v) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp_v);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && run_chk) begin
         for (int i = 0; i < N; i++) check(tag, ecount[i*W +: W], m_evt[i], $sformatf("evt_count[%0d]", i));
         check(tag, ccount, m_cyc, "cyc_count");
         check(tag, W'(ovf), W'(m_ovf), "ovf_flags");
         check(tag, W'(expo), W'(m_exp), "evt_export");
      end
   end

   task automatic step(input int n);
      for (int k = 0; k < n; k++) begin
         @(posedge clk); #1;
         wr = 0; eclr = 0; cclr = 0;
      end
   endtask

   task automatic rnd(input int n);
      for (int k = 0; k < n; k++) begin
         @(posedge clk); #1;
         wr = 0; eclr = 0; cclr = 0;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         pulse = lfsr[3:0];
      end
      @(posedge clk); #1; pulse = '0;
   endtask

   task automatic wreg(input int a, input logic [W-1:0] d);
      @(posedge clk); #1;
      eclr = 0; cclr = 0;
      wr = 1; addr = AW'(a); wdata = d;
      @(posedge clk); #1; wr = 0;
   endtask

   task automatic rd_check(input int a, input logic [W-1:0] exp_v, input string req);
      addr = AW'(a); #0.5;
      check(req, rdata, exp_v, $sformatf("reg_rdata@%0d", a));
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      logic [W-1:0] snap;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      run_chk = 1;
      @(negedge clk);
      // R11 reset state through the register port
      for (int a = 0; a < N + 3; a++) rd_check(a, '0, "R11");

      // R2 permitted: events count, cycle counts whatever hold is
      tag = "R2"; gen = 1; cen = 1; een = '1; allow = 1; hold = 1;
      rnd(20);
      hold = 0; rnd(10);

      // R3 not permitted, hold 0
      tag = "R3"; allow = 0; hold = 0;
      snap = ecount[W-1:0];
      rnd(15);
      @(negedge clk); check("R3", ecount[W-1:0], snap, "evt0 frozen while prohibited");

      // R4 not permitted, hold 1
      tag = "R4"; hold = 1;
      step(1); @(negedge clk); snap = ccount;
      rnd(10);
      @(negedge clk); check("R4", ccount, snap, "cycle counter held");

      // R1 halted with permission and export
      tag = "R1"; allow = 1; hold = 0; xen = 1; step(3);
      halted = 1;
      @(negedge clk); snap = ccount;
      rnd(12);
      @(negedge clk); check("R1", ccount, snap, "cycle counter halted");
      check("R1", W'(expo), '0, "no export in halted state");
      halted = 0;

      // R5 export qualification
      tag = "R5"; step(2); rnd(10);
      xen = 0; rnd(8);
      xen = 1; een = '0; rnd(8);
      allow = 0; rnd(6);
      een = '1; allow = 1; step(2);

      // R6 grant lag and immediate revoke
      tag = "R6";
      allow = 0; step(2);
      @(posedge clk); #1; eclr = 1;
      @(posedge clk); #1; eclr = 0; allow = 1; pulse = 4'b0001;
      @(posedge clk); #1; pulse = 4'b0001;
      @(posedge clk); #1; pulse = 4'b0001; allow = 0;
      @(posedge clk); #1; pulse = '0;
      @(negedge clk); check("R6", ecount[W-1:0], 32'd1, "only second pulse after grant counts");
      allow = 1; step(2);

      // R7 enables
      tag = "R7"; gen = 0; rnd(8);
      gen = 1; een = 4'b0101; cen = 0; rnd(10);
      een = '1; cen = 1; step(1);

      // R8 overflow wrap, sticky, W1C, set wins
      tag = "R8";
      wreg(1, '1);
      @(posedge clk); #1; pulse = 4'b0010;
      @(posedge clk); #1; pulse = '0;
      @(negedge clk);
      check("R8", ecount[W +: W], '0, "counter 1 wrapped");
      check("R8", W'(ovf[1]), 32'd1, "overflow bit 1 set");
      step(3);
      @(negedge clk); check("R8", W'(ovf[1]), 32'd1, "overflow bit 1 sticky");
      wreg(N + 1, 32'h2);
      @(negedge clk); check("R8", W'(ovf[1]), 32'd0, "overflow bit 1 cleared by W1C");
      // cycle counter wrap while clearing its flag in the same cycle
      wreg(N, 32'hFFFF_FFFE);
      @(posedge clk); #1; wr = 1; addr = AW'(N + 1); wdata = 32'h10;
      @(posedge clk); #1; wr = 0;
      @(negedge clk); check("R8", W'(ovf[N]), 32'd1, "wrap wins over clear");

      // R9 write beats clear beats increment; read map
      tag = "R9";
      @(posedge clk); #1; wr = 1; addr = 0; wdata = 32'h55; eclr = 1; pulse = '1;
      @(posedge clk); #1; wr = 0; eclr = 0; pulse = '0;
      @(negedge clk);
      check("R9", ecount[W-1:0], 32'h55, "write beats clear");
      check("R10", ecount[2*W +: W], '0, "clear beats increment");
      rd_check(0, 32'h55, "R9");
      rd_check(N + 2, '0, "R9");
      rd_check(N + 1, W'(m_ovf), "R9");
      rd_check(N, m_cyc, "R9");

      // R10 clears
      tag = "R10"; rnd(6);
      @(posedge clk); #1; cclr = 1;
      @(posedge clk); #1; cclr = 0; cen = 0;
      @(negedge clk); check("R10", ccount, '0, "cycle clear");
      cen = 1; step(2);

      tag = "R2"; rnd(20);
      run_chk = 0;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule